// File: doc/BRIEF.md
# SMM Memory Visibility Controller

This block keeps the two control bytes that decide where protected system-management memory is visible, and routes each memory access on the basis of those bytes. Three windows are handled: the 128 KiB legacy window at 0xA0000, its alias at 0xFEDA0000, and a TSEG region just below the top of low memory. For every access the block looks at the address and at a flag that says whether the access comes from system-management mode. It then picks one of three destinations: DRAM, the PCI/VGA side, or a sink. When the destination is DRAM it also gives the DRAM address to use.

Software programs the bytes through a simple byte write port. A sticky lock bit closes the open window and freezes most of the configuration until reset. Accesses that do not come from system-management mode and fall inside TSEG go to the sink. The sink returns all-ones on reads and throws writes away. The route is computed combinationally from the stored bytes, so a byte write affects the first access after the clock edge that stores it.

Top module: `smram_vis_ctrl`

## Requirements
- R1: After reset the main byte reads 0x02 and the extended byte reads 0x00.
- R2: In the main byte, only bit 6 (open), bit 5 (close), bit 4 (lock) and bit 3 (global enable) are writable, and bits 2:0 always read 010. In the extended byte, only bit 7 (high enable), bits 2:1 (TSEG size) and bit 0 (TSEG enable) are writable, and bits 6:3 read 0. `cfg_sel`=0 selects the main byte and `cfg_sel`=1 selects the extended byte.
- R3: Any write that leaves the lock bit set also clears the open bit in that same update. From then until reset, only the close bit of the main byte can be written, and the extended byte cannot be written at all.
- R4: For a non-SMM access to [0xA0000, 0xC0000), the route is DRAM when open=1 and high enable=0. Otherwise the route is PCI. Route codes are 00 = DRAM, 01 = PCI/VGA, 10 = sink.
- R5: For a non-SMM access to [0xFEDA0000, 0xFEDC0000), the route is DRAM when open=1 and high enable=1, with `dram_addr` = address − 0xFED00000. Otherwise the access takes the default route.
- R6: For an SMM access with global enable=1, the legacy window goes to DRAM when high enable=0, and the high alias goes to DRAM (translated as in R5) when high enable=1. Any window not claimed this way falls back to the non-SMM route.
- R7: When TSEG enable=1, the size field selects 1 MiB (00), 2 MiB (01) or 8 MiB (10). Size 11, or TSEG enable=0, gives an empty region. The region covers [mem_top − size, mem_top).
- R8: A non-SMM access inside TSEG is routed to the sink, and `bh_rdata` is then 0xFFFFFFFF. On every other route `bh_rdata` is 0.
- R9: An SMM access inside TSEG is routed to DRAM with `dram_addr` equal to the access address.
- R10: Any other address goes to DRAM when it is below `mem_top` and to PCI when it is at or above `mem_top`.
- R11: A byte write does not affect the route in the cycle it is presented. It takes effect from the first access after the storing clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Byte write strobe |
| cfg_sel | input | 1 | 0 = main byte, 1 = extended byte |
| cfg_wdata | input | 8 | Write data |
| smc_q | output | 8 | Main control byte readback |
| ext_q | output | 8 | Extended control byte readback |
| acc_smm | input | 1 | Access is made from system-management mode |
| acc_addr | input | ADDR_W | Access address |
| mem_top | input | ADDR_W | Size of memory below 4 GiB |
| route | output | 2 | Destination code |
| dram_addr | output | ADDR_W | DRAM address when routed to DRAM |
| bh_rdata | output | DATA_W | Read data returned by the sink |

## Verification
The route is checked with open on and off, high enable on and off, and global enable on and off, each for both SMM and non-SMM accesses. Probing the first and last byte of each window, and the byte just past it, separates the window decode from the default route. Every TSEG encoding, including the two that give an empty region, is probed at the region base and one byte below it, so a wrong size decode shows up as a misplaced boundary. A lock sequence followed by a reset shows that the lock is sticky, that it clears open at once, and that only reset lifts it.

// File: rtl/smram_vis_pkg.sv
package smram_vis_pkg;
  typedef enum logic [1:0] {
    RT_DRAM = 2'b00,
    RT_PCI  = 2'b01,
    RT_SINK = 2'b10
  } route_e;

  localparam int SMC_OPEN  = 6;
  localparam int SMC_CLOSE = 5;
  localparam int SMC_LOCK  = 4;
  localparam int SMC_GEN   = 3;
  localparam int EXT_HEN   = 7;

  localparam logic [7:0] SMC_RST      = 8'h02;
  localparam logic [7:0] SMC_WMASK    = 8'h78;
  localparam logic [7:0] SMC_WMASK_LK = 8'h20;
  localparam logic [7:0] EXT_RST      = 8'h00;
  localparam logic [7:0] EXT_WMASK    = 8'h87;
  localparam logic [7:0] EXT_WMASK_LK = 8'h00;
endpackage

// File: rtl/smram_regs.sv
module smram_regs
  import smram_vis_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] smc_q,
  output logic [7:0] ext_q
);
  logic [7:0] smc_wm, ext_wm;
  logic [7:0] smc_nxt, ext_nxt;

  always_comb begin
    smc_nxt = (smc_q & ~smc_wm) | (cfg_wdata & smc_wm);
    if (smc_nxt[SMC_LOCK]) smc_nxt[SMC_OPEN] = 1'b0;
    ext_nxt = (ext_q & ~ext_wm) | (cfg_wdata & ext_wm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smc_q  <= SMC_RST;
      ext_q  <= EXT_RST;
      smc_wm <= SMC_WMASK;
      ext_wm <= EXT_WMASK;
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        smc_q <= smc_nxt;
        if (smc_nxt[SMC_LOCK]) begin
          smc_wm <= SMC_WMASK_LK;
          ext_wm <= EXT_WMASK_LK;
        end
      end else begin
        ext_q <= ext_nxt;
      end
    end
  end
endmodule

// File: rtl/smram_tseg.sv
module smram_tseg #(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        tseg_cfg,
  input  logic [ADDR_W-1:0] mem_top,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              tseg_hit
);
  localparam logic [ADDR_W-1:0] SZ_1M = ADDR_W'(1) << 20;
  localparam logic [ADDR_W-1:0] SZ_2M = ADDR_W'(1) << 21;
  localparam logic [ADDR_W-1:0] SZ_8M = ADDR_W'(1) << 23;

  logic [ADDR_W-1:0] tseg_size;
  logic [ADDR_W-1:0] tseg_base;

  always_comb begin
    tseg_size = '0;
    if (tseg_cfg[0]) begin
      case (tseg_cfg[2:1])
        2'b00:   tseg_size = SZ_1M;
        2'b01:   tseg_size = SZ_2M;
        2'b10:   tseg_size = SZ_8M;
        default: tseg_size = '0;
      endcase
    end
    tseg_base = mem_top - tseg_size;
    tseg_hit  = (tseg_size != '0) && (acc_addr >= tseg_base) && (acc_addr < mem_top);
  end
endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_vis_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] LEG_BASE = 'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h0002_0000,
  parameter logic [ADDR_W-1:0] HI_BASE  = 'hFEDA_0000
) (
  input  logic              acc_smm,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] mem_top,
  input  logic              tseg_hit,
  input  logic              open_bit,
  input  logic              hen_bit,
  input  logic              gen_bit,
  output route_e            route,
  output logic [ADDR_W-1:0] dram_addr
);
  logic   in_leg, in_hi;
  logic   nv_alias, use_alias;
  route_e dflt_rt, nv_rt;

  always_comb begin
    in_leg  = (acc_addr >= LEG_BASE) && (acc_addr < LEG_BASE + WIN_SIZE);
    in_hi   = (acc_addr >= HI_BASE)  && (acc_addr < HI_BASE + WIN_SIZE);
    dflt_rt = (acc_addr < mem_top) ? RT_DRAM : RT_PCI;

    // view seen by ordinary (non-SMM) accesses
    nv_alias = 1'b0;
    if (tseg_hit)    nv_rt = RT_SINK;
    else if (in_leg) nv_rt = (open_bit && !hen_bit) ? RT_DRAM : RT_PCI;
    else if (in_hi && open_bit && hen_bit) begin
      nv_rt    = RT_DRAM;
      nv_alias = 1'b1;
    end else         nv_rt = dflt_rt;

    // SMM overlay on top of the ordinary view
    route     = nv_rt;
    use_alias = nv_alias;
    if (acc_smm) begin
      if (tseg_hit) begin
        route     = RT_DRAM;
        use_alias = 1'b0;
      end else if (in_leg && gen_bit && !hen_bit) begin
        route = RT_DRAM;
      end else if (in_hi && gen_bit && hen_bit) begin
        route     = RT_DRAM;
        use_alias = 1'b1;
      end
    end

    dram_addr = use_alias ? (acc_addr - HI_BASE + LEG_BASE) : acc_addr;
  end
endmodule

// File: rtl/smram_vis_ctrl.sv
module smram_vis_ctrl
  import smram_vis_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] LEG_BASE = 'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h0002_0000,
  parameter logic [ADDR_W-1:0] HI_BASE  = 'hFEDA_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        smc_q,
  output logic [7:0]        ext_q,
  input  logic              acc_smm,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] mem_top,
  output logic [1:0]        route,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [DATA_W-1:0] bh_rdata
);
  logic   tseg_hit;
  route_e rt;

  smram_regs u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .smc_q(smc_q), .ext_q(ext_q)
  );

  smram_tseg #(.ADDR_W(ADDR_W)) u_tseg (
    .tseg_cfg(ext_q[2:0]), .mem_top(mem_top), .acc_addr(acc_addr),
    .tseg_hit(tseg_hit)
  );

  smram_route #(
    .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .WIN_SIZE(WIN_SIZE), .HI_BASE(HI_BASE)
  ) u_route (
    .acc_smm(acc_smm), .acc_addr(acc_addr), .mem_top(mem_top),
    .tseg_hit(tseg_hit), .open_bit(smc_q[SMC_OPEN]), .hen_bit(ext_q[EXT_HEN]),
    .gen_bit(smc_q[SMC_GEN]), .route(rt), .dram_addr(dram_addr)
  );

  assign route    = rt;
  assign bh_rdata = (rt == RT_SINK) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
endmodule

// File: rtl/smram_vis_chk.sv
module smram_vis_chk #(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] LEG_BASE = 'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h0002_0000,
  parameter logic [ADDR_W-1:0] HI_BASE  = 'hFEDA_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        smc_q,
  input logic [7:0]        ext_q,
  input logic              acc_smm,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        route,
  input logic [ADDR_W-1:0] dram_addr,
  input logic [DATA_W-1:0] bh_rdata
);
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (smc_q[2:0] == 3'b010) && (ext_q[6:3] == 4'b0000));

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    smc_q[4] |=> smc_q[4]);

  a_r3_lock_closes: assert property (@(posedge clk) disable iff (rst)
    smc_q[4] |-> !smc_q[6]);

  a_r3_ext_frozen: assert property (@(posedge clk) disable iff (rst)
    smc_q[4] |=> $stable(ext_q));

  a_r5_alias_xlate: assert property (@(posedge clk) disable iff (rst)
    (route == 2'b00 && acc_addr >= HI_BASE && acc_addr < HI_BASE + WIN_SIZE)
      |-> dram_addr == acc_addr - HI_BASE + LEG_BASE);

  a_r8_sink_data: assert property (@(posedge clk) disable iff (rst)
    (route == 2'b10) |-> (bh_rdata == {DATA_W{1'b1}}));

  a_r9_no_sink_smm: assert property (@(posedge clk) disable iff (rst)
    acc_smm |-> (route != 2'b10));
endmodule

bind smram_vis_ctrl smram_vis_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEG_BASE(LEG_BASE),
  .WIN_SIZE(WIN_SIZE), .HI_BASE(HI_BASE)
) u_chk (
  .clk(clk), .rst(rst), .smc_q(smc_q), .ext_q(ext_q), .acc_smm(acc_smm),
  .acc_addr(acc_addr), .route(route), .dram_addr(dram_addr), .bh_rdata(bh_rdata)
);

// File: tb/smram_vis_ctrl_tb.sv
module smram_vis_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  smc_q, ext_q;
  logic        acc_smm = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic [31:0] mem_top = 32'h8000_0000;
  logic [1:0]  route;
  logic [31:0] dram_addr, bh_rdata;

  int total = 0;
  int bad = 0;

  localparam logic [1:0] DR = 2'b00, PC = 2'b01, SK = 2'b10;

  always #5 clk = ~clk;

  smram_vis_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .smc_q(smc_q), .ext_q(ext_q), .acc_smm(acc_smm), .acc_addr(acc_addr),
    .mem_top(mem_top), .route(route), .dram_addr(dram_addr), .bh_rdata(bh_rdata)
  );

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic chk_regs(input string tag, input logic [7:0] es, input logic [7:0] ee);
    total++;
    if (smc_q !== es || ext_q !== ee) begin
      bad++;
      $display("FAIL %s regs got %h/%h exp %h/%h", tag, smc_q, ext_q, es, ee);
    end
  endtask

  task automatic chk_acc(input string tag, input logic smm, input logic [31:0] a,
                         input logic [1:0] er, input logic [31:0] ed);
    logic [31:0] erd;
    acc_smm = smm; acc_addr = a;
    #1;
    erd = (er == SK) ? 32'hFFFF_FFFF : 32'h0;
    total++;
    if (route !== er || (er == DR && dram_addr !== ed) || bh_rdata !== erd) begin
      bad++;
      $display("FAIL %s addr %h smm %0b got rt=%b da=%h rd=%h exp rt=%b da=%h rd=%h",
               tag, a, smm, route, dram_addr, bh_rdata, er, ed, erd);
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset;
    do_reset();
    chk_regs("R1 reset", 8'h02, 8'h00);
    chk_acc("R4 closed legacy", 1'b0, 32'h000A_0000, PC, 0);
    chk_acc("R10 low dram", 1'b0, 32'h7FF0_0000, DR, 32'h7FF0_0000);
    chk_acc("R10 above top", 1'b0, 32'h9000_0000, PC, 0);
  endtask

  task automatic t_masks;
    wr(1'b0, 8'hCF);
    chk_regs("R2 main mask", 8'h4A, 8'h00);
    wr(1'b1, 8'hFF);
    chk_regs("R2 ext mask", 8'h4A, 8'h87);
  endtask

  task automatic t_open_high;
    // open=1 gen=1 hen=1, TSEG size code 11 -> empty
    chk_acc("R4 open hen legacy", 1'b0, 32'h000A_0000, PC, 0);
    chk_acc("R5 alias first", 1'b0, 32'hFEDA_0000, DR, 32'h000A_0000);
    chk_acc("R5 alias last", 1'b0, 32'hFEDB_FFFF, DR, 32'h000B_FFFF);
    chk_acc("R5 past alias", 1'b0, 32'hFEDC_0000, PC, 0);
    chk_acc("R7 size11 empty", 1'b0, 32'h7FFF_FFFF, DR, 32'h7FFF_FFFF);
  endtask

  task automatic t_open_low;
    wr(1'b1, 8'h00);
    chk_acc("R4 open legacy", 1'b0, 32'h000A_0000, DR, 32'h000A_0000);
    chk_acc("R4 open legacy last", 1'b0, 32'h000B_FFFF, DR, 32'h000B_FFFF);
    chk_acc("R5 alias hidden", 1'b0, 32'hFEDA_0000, PC, 0);
    chk_acc("R10 past legacy", 1'b0, 32'h000C_0000, DR, 32'h000C_0000);
  endtask

  task automatic t_smm;
    wr(1'b0, 8'h08);
    chk_acc("R4 closed non-smm", 1'b0, 32'h000A_0000, PC, 0);
    chk_acc("R6 smm low", 1'b1, 32'h000A_0000, DR, 32'h000A_0000);
    chk_acc("R6 smm alias off", 1'b1, 32'hFEDA_0000, PC, 0);
    wr(1'b1, 8'h80);
    chk_acc("R6 smm alias", 1'b1, 32'hFEDA_0000, DR, 32'h000A_0000);
    chk_acc("R6 smm low fallback", 1'b1, 32'h000A_0000, PC, 0);
    wr(1'b0, 8'h00);
    chk_acc("R6 gen off low", 1'b1, 32'h000A_0000, PC, 0);
    chk_acc("R6 gen off alias", 1'b1, 32'hFEDA_0000, PC, 0);
  endtask

  task automatic t_tseg;
    wr(1'b1, 8'h01);
    chk_acc("R8 1M base", 1'b0, 32'h7FF0_0000, SK, 0);
    chk_acc("R8 1M top", 1'b0, 32'h7FFF_FFFF, SK, 0);
    chk_acc("R7 1M below", 1'b0, 32'h7FEF_FFFF, DR, 32'h7FEF_FFFF);
    chk_acc("R10 at top", 1'b0, 32'h8000_0000, PC, 0);
    chk_acc("R9 smm tseg", 1'b1, 32'h7FF0_0000, DR, 32'h7FF0_0000);
    wr(1'b1, 8'h03);
    chk_acc("R7 2M base", 1'b0, 32'h7FE0_0000, SK, 0);
    chk_acc("R7 2M below", 1'b0, 32'h7FDF_FFFF, DR, 32'h7FDF_FFFF);
    wr(1'b1, 8'h05);
    chk_acc("R7 8M base", 1'b0, 32'h7F80_0000, SK, 0);
    chk_acc("R7 8M below", 1'b0, 32'h7F7F_FFFF, DR, 32'h7F7F_FFFF);
    wr(1'b1, 8'h07);
    chk_acc("R7 code11", 1'b0, 32'h7FF0_0000, DR, 32'h7FF0_0000);
    wr(1'b1, 8'h04);
    chk_acc("R7 disabled", 1'b0, 32'h7FF0_0000, DR, 32'h7FF0_0000);
  endtask

  task automatic t_timing;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h01;
    chk_acc("R11 before edge", 1'b0, 32'h7FF0_0000, DR, 32'h7FF0_0000);
    @(negedge clk);
    cfg_we = 1'b0;
    chk_acc("R11 after edge", 1'b0, 32'h7FF0_0000, SK, 0);
  endtask

  task automatic t_lock;
    wr(1'b0, 8'h48);
    wr(1'b1, 8'h81);
    chk_regs("R3 pre-lock", 8'h4A, 8'h81);
    wr(1'b0, 8'h58);
    chk_regs("R3 lock clears open", 8'h1A, 8'h81);
    wr(1'b0, 8'h78);
    chk_regs("R3 only close writable", 8'h3A, 8'h81);
    wr(1'b0, 8'h00);
    chk_regs("R3 lock sticky", 8'h1A, 8'h81);
    wr(1'b1, 8'h00);
    chk_regs("R3 ext frozen", 8'h1A, 8'h81);
    chk_acc("R3 alias hidden after lock", 1'b0, 32'hFEDA_0000, PC, 0);
    do_reset();
    chk_regs("R1 reset after lock", 8'h02, 8'h00);
    wr(1'b0, 8'h48);
    chk_regs("R3 reset unlocks", 8'h4A, 8'h00);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_masks();
    t_open_high();
    t_open_low();
    t_smm();
    t_tseg();
    t_timing();
    t_lock();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule